// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address by reading a two-level translation structure held in memory. Each request carries a linear address, a write flag and a user-privilege flag. The block takes it while idle and looks up a directory entry. Unless that entry maps a 4 MiB page, it then looks up a table entry. Along the way it checks the present bit and the access rights. It sets the accessed flag of every entry used, and the dirty flag of the leaf entry on a write, writing the updated entries back through the same memory port. It finishes with either a physical address or a fault that carries a reason.

Table entries are read and written over a simple 32-bit memory port. A read is a one-cycle `mem_req` with `mem_we` low, answered later by `mem_rvalid` with `mem_rdata`. A write is a one-cycle `mem_req` with `mem_we` high, which the memory takes in that cycle. When translation is switched off, the block returns the linear address unchanged. The walker handles one request at a time and holds no translation cache.

Top module: `ptw_walker`

## Requirements
- R1: When `paging_en` is low at acceptance, `done` rises in the cycle after the accepting edge, `phys_addr` equals the linear address, `phys_wt`/`phys_cd` are 0, and no memory access is made.
- R2: The first read goes to the directory base with its low 12 bits cleared plus linear bits 31:22 times 4. The second read goes to directory-entry bits 31:12 followed by 12 zero bits, plus linear bits 21:12 times 4.
- R3: For a 4 KiB page, `phys_addr` is table-entry bits 31:12 joined with linear bits 11:0. `phys_wt` is taken from entry bit 3 and `phys_cd` from entry bit 4. Entry bits 11:9 have no effect.
- R4: A directory entry with bit 7 set while `large_en` is high ends the walk after one read, with `phys_addr` = entry bits 31:22 joined with linear bits 21:0. When `large_en` is low, bit 7 is ignored and the table is read.
- R5: An entry with bit 0 (present) clear ends the walk with a not-present fault at that level. The table is not read after a non-present directory entry.
- R6: A supervisor request (`req_user`=0) is never refused on rights. A user request faults when bit 2 (user) of a checked entry is 0. A user write faults when bit 1 (writable) of a checked entry is 0. The directory entry is checked before the table is read.
- R7: On success, bit 5 (accessed) is set in every entry used, and bit 6 (dirty) is set in the leaf entry on a write. An entry is written only when its value changes, and the directory entry is written before the table entry.
- R8: A walk that faults writes nothing to memory.
- R9: A fault reports `fault_level` (0 directory, 1 table), `fault_prot` (0 not present, 1 rights), and copies of the request's write and user flags.
- R10: Each accepted request yields exactly one single-cycle pulse, either `done` or `fault` and never both. `busy` is high during a walk, and requests made while busy are ignored.
- R11: The outcome appears after a fixed number of edges past the accepting edge: 2 per entry read, plus 1 per write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when not busy |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request runs at user level |
| dir_base | input | 32 | Directory base address (low 12 bits ignored) |
| paging_en | input | 1 | Translation enable |
| large_en | input | 1 | 4 MiB page enable |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | Successful translation pulse |
| fault | output | 1 | Fault pulse |
| phys_addr | output | 32 | Physical address |
| phys_wt | output | 1 | Write-through bit of the leaf entry |
| phys_cd | output | 1 | Cache-disable bit of the leaf entry |
| fault_level | output | 1 | Level that failed |
| fault_prot | output | 1 | 1 for a rights fault, 0 for not present |
| fault_write | output | 1 | Write flag of the faulting request |
| fault_user | output | 1 | User flag of the faulting request |

## Verification
The bench's memory model answers a read one edge after it sees the strobe. Each result therefore has a fixed delay, counted from the accepting edge: 0 edges with translation off, 2 for a directory-level outcome, 4 for a table-level outcome, plus one edge for each entry written back. The bench counts negative edges from acceptance until `done` or `fault` is seen and compares that count with the delay it has worked out. It samples outputs and memory at that negative edge, then watches two more cycles to confirm that no second completion follows.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // entry flag positions (shared by both levels; B_DIRTY and B_BIG used by leaf/directory)
  localparam int B_PRES  = 0;
  localparam int B_RW    = 1;
  localparam int B_USR   = 2;
  localparam int B_WT    = 3;
  localparam int B_CD    = 4;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_BIG   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_WAIT,
    ST_TBL_WAIT,
    ST_WB_TBL,
    ST_FIN
  } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10
) (
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [ADDR_W-1:0] lin_new,
  input  logic [ADDR_W-1:0] lin_walk,
  input  logic [ADDR_W-1:0] ent,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [ADDR_W-1:0] phys_small,
  output logic [ADDR_W-1:0] phys_large
);
  localparam int LARGE_SHIFT = PAGE_SHIFT + IDX_W;
  localparam int OFF_W       = IDX_W + 2;

  logic [ADDR_W-1:0] dir_off, tbl_off;

  always_comb begin
    dir_off = '0;
    tbl_off = '0;
    dir_off[OFF_W-1:0] = {lin_new[ADDR_W-1 -: IDX_W], 2'b00};
    tbl_off[OFF_W-1:0] = {lin_walk[LARGE_SHIFT-1:PAGE_SHIFT], 2'b00};
  end

  assign dir_addr   = {dir_base[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} + dir_off;
  assign tbl_addr   = {ent[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}} + tbl_off;
  assign phys_small = {ent[ADDR_W-1:PAGE_SHIFT], lin_walk[PAGE_SHIFT-1:0]};
  assign phys_large = {ent[ADDR_W-1:LARGE_SHIFT], lin_walk[LARGE_SHIFT-1:0]};

  logic unused_bits;
  assign unused_bits = ^{dir_base[PAGE_SHIFT-1:0], lin_new[ADDR_W-IDX_W-1:0],
                         lin_walk[ADDR_W-1:LARGE_SHIFT]};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ent,
  input  logic              req_write,
  input  logic              req_user,
  input  logic              mark_dirty,
  output logic              present,
  output logic              rights_ok,
  output logic [ADDR_W-1:0] ent_upd,
  output logic              need_wb
);
  import ptw_pkg::*;

  always_comb begin
    present   = ent[B_PRES];
    rights_ok = !req_user || (ent[B_USR] && (!req_write || ent[B_RW]));
    ent_upd   = ent;
    ent_upd[B_ACC] = 1'b1;
    if (mark_dirty) ent_upd[B_DIRTY] = 1'b1;
    need_wb   = (ent_upd != ent);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_lin,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              paging_en,
  input  logic              large_en,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              phys_wt,
  output logic              phys_cd,
  output logic              fault_level,
  output logic              fault_prot,
  output logic              fault_write,
  output logic              fault_user
);
  import ptw_pkg::*;

  walk_state_t       state;
  logic [ADDR_W-1:0] lin_q, pde_addr_q, pte_addr_q, pde_new_q, pte_new_q;
  logic              wr_q, usr_q, large_q, pde_wb_q, pte_wb_q;

  logic [ADDR_W-1:0] dir_addr, tbl_addr, phys_small, phys_large, ent_upd;
  logic              ent_present, ent_rights_ok, ent_need_wb, is_big, mark_dirty;

  assign busy       = (state != ST_IDLE);
  assign is_big     = large_q && mem_rdata[B_BIG];
  assign mark_dirty = wr_q && ((state == ST_TBL_WAIT) || is_big);

  ptw_addr_gen #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)) u_addr (
    .dir_base  (dir_base),
    .lin_new   (req_lin),
    .lin_walk  (lin_q),
    .ent       (mem_rdata),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr),
    .phys_small(phys_small),
    .phys_large(phys_large)
  );

  ptw_entry_eval #(.ADDR_W(ADDR_W)) u_eval (
    .ent       (mem_rdata),
    .req_write (wr_q),
    .req_user  (usr_q),
    .mark_dirty(mark_dirty),
    .present   (ent_present),
    .rights_ok (ent_rights_ok),
    .ent_upd   (ent_upd),
    .need_wb   (ent_need_wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      phys_addr   <= '0;
      phys_wt     <= 1'b0;
      phys_cd     <= 1'b0;
      fault_level <= 1'b0;
      fault_prot  <= 1'b0;
      fault_write <= 1'b0;
      fault_user  <= 1'b0;
      lin_q       <= '0;
      pde_addr_q  <= '0;
      pte_addr_q  <= '0;
      pde_new_q   <= '0;
      pte_new_q   <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      large_q     <= 1'b0;
      pde_wb_q    <= 1'b0;
      pte_wb_q    <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            lin_q   <= req_lin;
            wr_q    <= req_write;
            usr_q   <= req_user;
            large_q <= large_en;
            if (!paging_en) begin
              phys_addr <= req_lin;
              phys_wt   <= 1'b0;
              phys_cd   <= 1'b0;
              done      <= 1'b1;
            end else begin
              mem_req    <= 1'b1;
              mem_addr   <= dir_addr;
              pde_addr_q <= dir_addr;
              state      <= ST_DIR_WAIT;
            end
          end
        end
        ST_DIR_WAIT: begin
          if (mem_rvalid) begin
            if (!ent_present || !ent_rights_ok) begin
              fault       <= 1'b1;
              fault_level <= 1'b0;
              fault_prot  <= ent_present;
              fault_write <= wr_q;
              fault_user  <= usr_q;
              state       <= ST_IDLE;
            end else if (is_big) begin
              phys_addr <= phys_large;
              phys_wt   <= mem_rdata[B_WT];
              phys_cd   <= mem_rdata[B_CD];
              if (ent_need_wb) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= pde_addr_q;
                mem_wdata <= ent_upd;
                state     <= ST_FIN;
              end else begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end else begin
              pde_new_q  <= ent_upd;
              pde_wb_q   <= ent_need_wb;
              mem_req    <= 1'b1;
              mem_addr   <= tbl_addr;
              pte_addr_q <= tbl_addr;
              state      <= ST_TBL_WAIT;
            end
          end
        end
        ST_TBL_WAIT: begin
          if (mem_rvalid) begin
            if (!ent_present || !ent_rights_ok) begin
              fault       <= 1'b1;
              fault_level <= 1'b1;
              fault_prot  <= ent_present;
              fault_write <= wr_q;
              fault_user  <= usr_q;
              state       <= ST_IDLE;
            end else begin
              phys_addr <= phys_small;
              phys_wt   <= mem_rdata[B_WT];
              phys_cd   <= mem_rdata[B_CD];
              pte_new_q <= ent_upd;
              pte_wb_q  <= ent_need_wb;
              if (pde_wb_q) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= pde_addr_q;
                mem_wdata <= pde_new_q;
                state     <= ST_WB_TBL;
              end else if (ent_need_wb) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= pte_addr_q;
                mem_wdata <= ent_upd;
                state     <= ST_FIN;
              end else begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_WB_TBL: begin
          if (pte_wb_q) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= pte_addr_q;
            mem_wdata <= pte_new_q;
            state     <= ST_FIN;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  busy,
  input logic                  paging_en,
  input logic [ADDR_W-1:0]     req_lin,
  input logic [PAGE_SHIFT-1:0] lin_lo,
  input logic                  done,
  input logic                  fault,
  input logic [ADDR_W-1:0]     phys_addr,
  input logic                  mem_req,
  input logic                  mem_we,
  input logic                  wdata_acc
);
  assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !paging_en) |=> (done && phys_addr == $past(req_lin) && !mem_req));

  assert_offset_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (phys_addr[PAGE_SHIFT-1:0] == lin_lo));

  assert_accessed_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> wdata_acc);

  assert_no_fault_after_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> !fault);

  assert_single_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  assert_idle_at_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    (done || fault) |-> !busy);

  assert_read_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> !mem_req);
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .paging_en(paging_en),
  .req_lin  (req_lin),
  .lin_lo   (lin_q[PAGE_SHIFT-1:0]),
  .done     (done),
  .fault    (fault),
  .phys_addr(phys_addr),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .wdata_acc(mem_wdata[ptw_pkg::B_ACC])
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_lin = '0, dir_base = '0;
  logic        paging_en = 1'b0, large_en = 1'b0;
  logic        busy, mem_req, mem_we, done, fault, phys_wt, phys_cd;
  logic        fault_level, fault_prot, fault_write, fault_user;
  logic [31:0] mem_addr, mem_wdata, phys_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
    .paging_en(paging_en), .large_en(large_en), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .phys_addr(phys_addr), .phys_wt(phys_wt), .phys_cd(phys_cd),
    .fault_level(fault_level), .fault_prot(fault_prot),
    .fault_write(fault_write), .fault_user(fault_user)
  );

  // memory model: read data one edge after the strobe, writes taken at once
  logic [31:0] mem [0:4095];
  logic        clr = 1'b0, tb_we = 1'b0;
  logic [11:0] tb_idx = '0;
  logic [31:0] tb_data = '0;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_log0 = '0, rd_log1 = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (tb_we) mem[tb_idx] <= tb_data;
    if (clr) begin
      rd_cnt <= 0;
      wr_cnt <= 0;
    end else if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[13:2]];
        if (rd_cnt == 0) rd_log0 <= mem_addr;
        if (rd_cnt == 1) rd_log1 <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] idx, input logic [31:0] d);
    tb_we = 1'b1; tb_idx = idx; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // issue one request at a negedge; returns edges from acceptance to outcome
  task automatic walk(input logic [31:0] lin, input logic w, input logic u,
                      output int lat, output bit to);
    req_valid = 1'b1; req_lin = lin; req_write = w; req_user = u; clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; clr = 1'b0;
    lat = 0; to = 1'b0;
    while (!(done || fault)) begin
      @(negedge clk);
      lat++;
      if (lat > 40) begin to = 1'b1; break; end
    end
  endtask

  task automatic quiet_after(input string req);
    int extra = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (done || fault) extra++;
    end
    check(extra == 0, req, "extra completion", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lat;
    bit to;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !fault && !mem_req, "R10", "reset outputs",
          {60'd0, busy, done, fault, mem_req}, 64'd0);

    // translation off
    paging_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] a;
      a = 32'h1357_9BDF * (k + 1) + 32'h0F0F_1234;
      walk(a, k[0], k[1], lat, to);
      check(done && !to, "R1", "bypass done", {63'd0, done}, 64'd1);
      check(phys_addr == a && !phys_wt && !phys_cd, "R1", "bypass addr",
            {30'd0, phys_wt, phys_cd, phys_addr}, {32'd0, a});
      check(lat == 0 && rd_cnt == 0 && wr_cnt == 0, "R1", "bypass latency/reads",
            64'(lat * 256 + rd_cnt * 16 + wr_cnt), 64'd0);
      quiet_after("R10");
    end

    // near-exhaustive sweep of entry flags and request kinds
    paging_en = 1'b1;
    for (int i = 0; i < 8192; i++) begin
      logic [31:0] h, hp, lin, pde, pte, base, e_phys, e_pde, e_pte, e_rd0, e_rd1;
      logic [1:0]  tsel;
      logic        w, u, le, e_fault, e_lvl, e_prot, e_wt, e_cd;
      int          e_wr, e_lat, e_rd;
      string       tag;
      h    = i * 32'h9E37_79B1 + 32'h7F4A_7C15;
      hp   = i * 32'h85EB_CA6B + 32'h1234_5678;
      lin  = h;
      w    = i[10]; u = i[11]; le = i[12];
      tsel = 2'(1 + (i % 3));
      base = {hp[31:14], 2'b00, hp[11:0]};
      pde  = {h[31:22], 8'h00, tsel, h[2:0], 1'b0, i[4], i[9], i[3], h[4], h[5],
              i[2], i[1], i[0]};
      pte  = {hp[31:12], h[8:6], 2'b00, i[9], i[8], h[9], h[10], i[7], i[6], i[5]};
      dir_base = base;
      large_en = le;
      poke({2'b00, lin[31:22]}, pde);
      poke({tsel, lin[21:12]}, pte);

      e_rd0 = {base[31:12], 12'h000} + {20'd0, lin[31:22], 2'b00};
      e_rd1 = {pde[31:12], 12'h000} + {20'd0, lin[21:12], 2'b00};
      e_pde = pde; e_pte = pte; e_wr = 0; e_phys = '0; e_wt = 0; e_cd = 0;
      e_fault = 0; e_lvl = 0; e_prot = 0; e_rd = 2;
      if (!pde[0]) begin
        e_fault = 1; e_lat = 2; e_rd = 1; tag = "R5";
      end else if (u && (!pde[2] || (w && !pde[1]))) begin
        e_fault = 1; e_prot = 1; e_lat = 2; e_rd = 1; tag = "R6";
      end else if (le && pde[7]) begin
        e_pde = pde | 32'h20 | (w ? 32'h40 : 32'h0);
        e_wr  = (e_pde != pde) ? 1 : 0;
        e_lat = 2 + e_wr; e_rd = 1;
        e_phys = {pde[31:22], lin[21:0]}; e_wt = pde[3]; e_cd = pde[4]; tag = "R4";
      end else if (!pte[0]) begin
        e_fault = 1; e_lvl = 1; e_lat = 4; tag = "R5";
      end else if (u && (!pte[2] || (w && !pte[1]))) begin
        e_fault = 1; e_lvl = 1; e_prot = 1; e_lat = 4; tag = "R6";
      end else begin
        e_pde = pde | 32'h20;
        e_pte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
        e_wr  = ((e_pde != pde) ? 1 : 0) + ((e_pte != pte) ? 1 : 0);
        e_lat = 4 + e_wr;
        e_phys = {pte[31:12], lin[11:0]}; e_wt = pte[3]; e_cd = pte[4]; tag = "R3";
      end

      walk(lin, w, u, lat, to);
      check(!to && done == !e_fault && fault == e_fault, "R10", "outcome kind",
            {62'd0, done, fault}, {62'd0, !e_fault, e_fault});
      if (e_fault)
        check({fault_level, fault_prot, fault_write, fault_user} == {e_lvl, e_prot, w, u},
              "R9", "fault info",
              {60'd0, fault_level, fault_prot, fault_write, fault_user},
              {60'd0, e_lvl, e_prot, w, u});
      else
        check(phys_addr == e_phys && phys_wt == e_wt && phys_cd == e_cd, tag,
              "translation", {30'd0, phys_wt, phys_cd, phys_addr},
              {30'd0, e_wt, e_cd, e_phys});
      check(lat == e_lat, "R11", "latency", 64'(lat), 64'(e_lat));
      check(rd_cnt == e_rd && rd_log0 == e_rd0 && (e_rd == 1 || rd_log1 == e_rd1),
            "R2", "entry read addresses", {rd_log0, rd_log1}, {e_rd0, e_rd1});
      check(wr_cnt == e_wr, e_fault ? "R8" : "R7", "write-back count",
            64'(wr_cnt), 64'(e_wr));
      check(mem[{2'b00, lin[31:22]}] == e_pde && mem[{tsel, lin[21:12]}] == e_pte,
            e_fault ? "R8" : "R7", "entries after walk",
            {mem[{2'b00, lin[31:22]}], mem[{tsel, lin[21:12]}]}, {e_pde, e_pte});
      quiet_after("R10");
    end

    // a request while busy is ignored
    begin
      logic [31:0] l1, l2;
      l1 = 32'h0040_3ABC; l2 = 32'h0080_5DEF;
      dir_base = 32'h0000_0000; large_en = 1'b0;
      poke({2'b00, l1[31:22]}, 32'h0000_1027);
      poke({2'b01, l1[21:12]}, 32'hCAFE_5067);
      req_valid = 1'b1; req_lin = l1; req_write = 1'b0; req_user = 1'b0; clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0; req_lin = l2; req_write = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!(done || fault) && lat < 40) begin @(negedge clk); lat++; end
      check(done && phys_addr == 32'hCAFE_5ABC, "R10", "busy request ignored",
            {31'd0, done, phys_addr}, {32'd1, 32'hCAFE_5ABC});
      check(rd_cnt == 2 && wr_cnt == 0, "R10", "no access for ignored request",
            64'(rd_cnt * 16 + wr_cnt), 64'd32);
      quiet_after("R10");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule